// File: doc/BRIEF.md
# Data-link message frame receiver

This block receives a serial data-link channel, one bit for each strobe, such as the overhead bits taken from incoming carrier frames. It hunts for flag octets (0x7E) and drops the zero inserted after five ones. It assembles octets least significant bit first. It then checks each message between two flags against a fixed three-octet header: an address octet, a terminal octet and a control octet. Next it decodes the message-type octet that opens the information field. From that octet it knows the information length, either 76 or 82 octets, and it checks the length against it. Finally it verifies the 16-bit frame check sequence.

Information octets go to an external buffer through a byte-wide write port, indexed from the type octet. Each result is posted to a status register that can be read through a two-register interface. An interrupt line goes high when a message completes, but only if the interrupt is enabled. Reading the control register clears that interrupt.

Top module: `lapd_rx`

## Requirements
- R1: While the enable bit (control bit 2, register address 0) is 0, strobed bits are ignored. The status register and the control interrupt bit do not change, and no payload write is made.
- R2: When the flag pattern 0x7E is received while enabled (bits taken least significant first), flag-present (status bit 0, register address 1) is set. It is cleared when the first octet of a message completes.
- R3: Within a message, a 0 that follows five consecutive 1s is removed. A payload made only of 0xFF octets is delivered unchanged.
- R4: The address octet must be 0x3C or 0x3E, the terminal octet 0x01 and the control octet 0x03. A mismatch discards the message: no end-of-message and no payload writes. For an accepted message, bit 1 of the address octet is reported in status bit 3.
- R5: The type octet maps to status bits 5:4 as follows: 0x38 gives 00, 0x34 gives 01, 0x32 gives 10 and 0x3F gives 11. Any other value discards the message.
- R6: The information field, type octet included, must be 82 octets long for type 0x3F and 76 octets for the other types. Any other length discards the message without end-of-message.
- R7: Information octet k, where k=0 is the type octet, is written to payload address k. Only the first expected-length octets are written.
- R8: The check sequence covers the header and the information field. It uses the generator x^16+x^12+x^5+1 with an all-ones preset and is sent inverted. When the receive residue is not 0xF0B8, status bit 2 is set and end-of-message is still reported.
- R9: Seven consecutive 1s after at least one message octet set abort (status bit 6) and drop the message without end-of-message.
- R10: A closing flag on a valid message sets end-of-message (status bit 1). If interrupt enable (control bit 1) is set, it also sets the interrupt status (control bit 0) and irq_o. A control-register read clears both.
- R11: Consecutive flags are idle fill and leave the status unchanged. A single flag can close one message and open the next.
- R12: End-of-message, abort and check-error are cleared when the first octet of the next message completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dl_bit_i | input | 1 | Serial data-link bit |
| dl_vld_i | input | 1 | Strobe, dl_bit_i is valid |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears interrupt on address 0) |
| reg_addr_i | input | 1 | 0 = control, 1 = status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt, high while interrupt status is set |
| pay_we_o | output | 1 | Payload buffer write enable |
| pay_addr_o | output | 7 | Payload buffer address |
| pay_data_o | output | 8 | Payload buffer write data |

## Verification
The hardest cases to reach from the ports are a stuffed zero that sits right before a closing flag and a flag that is shared between two messages. An all-ones payload drives the first case: it forces stuffing in every octet, right up to the check sequence. The bench reaches the second case by sending one message directly after another with no idle flag in between, and it reads the status in the gap. Aborts are forced by injecting eight raw ones partway through a message. A seeded random series then mixes the four message types, both C/R values and corrupted check sequences.

// File: rtl/lapd_rx_pkg.sv
package lapd_rx_pkg;
  localparam logic [7:0] ADDR_CMD  = 8'h3C;
  localparam logic [7:0] ADDR_RSP  = 8'h3E;
  localparam logic [7:0] TEI_OCT   = 8'h01;
  localparam logic [7:0] CTRL_OCT  = 8'h03;
  localparam logic [15:0] FCS_GOOD = 16'hF0B8;

  typedef struct packed {
    logic       ok;
    logic [1:0] code;
    logic       long_msg;
  } type_dec_t;

  function automatic type_dec_t decode_type(input logic [7:0] oct);
    type_dec_t d;
    d = '0;
    case (oct)
      8'h38: begin d.ok = 1'b1; d.code = 2'd0; end
      8'h34: begin d.ok = 1'b1; d.code = 2'd1; end
      8'h32: begin d.ok = 1'b1; d.code = 2'd2; end
      8'h3F: begin d.ok = 1'b1; d.code = 2'd3; d.long_msg = 1'b1; end
      default: d = '0;
    endcase
    return d;
  endfunction

  // reflected CRC-16, LSB-first octet
  function automatic logic [15:0] crc_octet(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/lapd_bit_deframer.sv
module lapd_bit_deframer (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       bit_i,
  input  logic       bit_vld_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       flag_o,
  output logic       aligned_o,
  output logic       abort_o
);
  logic [2:0] ones_q;
  logic [2:0] cnt_q;
  logic [6:0] sh_q;
  logic       take, is_flag, is_abort;

  always_comb begin
    is_flag  = bit_vld_i && !bit_i && (ones_q == 3'd6);
    is_abort = bit_vld_i && bit_i && (ones_q == 3'd6);
    // ones beyond the fifth are held back; a 0 after five ones is stuffing
    take     = bit_vld_i && (bit_i ? (ones_q < 3'd5) : (ones_q != 3'd6 && ones_q != 3'd5));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q     <= '0;
      cnt_q      <= '0;
      sh_q       <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      flag_o     <= 1'b0;
      aligned_o  <= 1'b0;
      abort_o    <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      flag_o     <= 1'b0;
      abort_o    <= 1'b0;
      if (!en_i) begin
        ones_q <= '0;
        cnt_q  <= '0;
      end else if (bit_vld_i) begin
        if (!bit_i)                 ones_q <= '0;
        else if (ones_q != 3'd7)    ones_q <= ones_q + 3'd1;
        if (is_abort) abort_o <= 1'b1;
        if (is_flag) begin
          flag_o    <= 1'b1;
          aligned_o <= (cnt_q == 3'd6);
          cnt_q     <= '0;
        end else if (take) begin
          sh_q  <= {bit_i, sh_q[6:1]};
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            byte_vld_o <= 1'b1;
            byte_o     <= {bit_i, sh_q};
          end
        end
      end
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(byte_vld_o || flag_o || abort_o)); // R1
  AST_FLAG_BYTE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_o && byte_vld_o)); // R2
  AST_FLAG_ABORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_o && abort_o)); // R9
endmodule

// File: rtl/lapd_frame_check.sv
module lapd_frame_check #(
  parameter int SHORT_LEN = 76,
  parameter int LONG_LEN  = 82,
  parameter int PAY_AW    = $clog2(LONG_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              flag_i,
  input  logic              aligned_i,
  input  logic              abort_i,
  output logic              start_o,
  output logic              eom_o,
  output logic              fcs_err_o,
  output logic [1:0]        type_o,
  output logic              cr_o,
  output logic              abort_o,
  output logic              pay_we_o,
  output logic [PAY_AW-1:0] pay_addr_o,
  output logic [7:0]        pay_data_o
);
  import lapd_rx_pkg::*;

  localparam int HDR_OCT = 3;
  localparam int FCS_OCT = 2;
  localparam int CNT_W   = $clog2(LONG_LEN + HDR_OCT + FCS_OCT + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             in_frame_q, bad_q, cr_q;
  logic [CNT_W-1:0] cnt_q, len_q, len_cur;
  logic [15:0]      crc_q;
  logic [1:0]       type_q;
  type_dec_t        dec;
  logic             hdr_bad, bad_cur, pay_ok, frame_ok;

  always_comb begin
    dec     = decode_type(byte_i);
    hdr_bad = (cnt_q == CNT_W'(0) && byte_i != ADDR_CMD && byte_i != ADDR_RSP) ||
              (cnt_q == CNT_W'(1) && byte_i != TEI_OCT) ||
              (cnt_q == CNT_W'(2) && byte_i != CTRL_OCT) ||
              (cnt_q == CNT_W'(HDR_OCT) && !dec.ok);
    len_cur = len_q;
    if (cnt_q == CNT_W'(HDR_OCT))
      len_cur = !dec.ok ? '0 : (dec.long_msg ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN));
    bad_cur  = bad_q || hdr_bad;
    pay_ok   = (cnt_q >= CNT_W'(HDR_OCT)) && !bad_cur &&
               ((cnt_q - CNT_W'(HDR_OCT)) < len_cur);
    frame_ok = in_frame_q && (cnt_q != '0) && aligned_i && !bad_q && (len_q != '0) &&
               (cnt_q == len_q + CNT_W'(HDR_OCT + FCS_OCT));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      bad_q      <= 1'b0;
      cr_q       <= 1'b0;
      cnt_q      <= '0;
      len_q      <= '0;
      crc_q      <= '1;
      type_q     <= '0;
      start_o    <= 1'b0;
      eom_o      <= 1'b0;
      fcs_err_o  <= 1'b0;
      type_o     <= '0;
      cr_o       <= 1'b0;
      abort_o    <= 1'b0;
      pay_we_o   <= 1'b0;
      pay_addr_o <= '0;
      pay_data_o <= '0;
    end else begin
      start_o  <= 1'b0;
      eom_o    <= 1'b0;
      abort_o  <= 1'b0;
      pay_we_o <= 1'b0;
      if (!en_i) begin
        in_frame_q <= 1'b0;
      end else if (flag_i) begin
        if (frame_ok) begin
          eom_o     <= 1'b1;
          fcs_err_o <= (crc_q != FCS_GOOD);
          type_o    <= type_q;
          cr_o      <= cr_q;
        end
        // every flag may open the next message
        in_frame_q <= 1'b1;
        cnt_q      <= '0;
        bad_q      <= 1'b0;
        len_q      <= '0;
        crc_q      <= '1;
      end else if (abort_i) begin
        if (in_frame_q && cnt_q != '0) abort_o <= 1'b1;
        in_frame_q <= 1'b0;
      end else if (byte_vld_i && in_frame_q) begin
        crc_q <= crc_octet(crc_q, byte_i);
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
        bad_q <= bad_cur;
        len_q <= len_cur;
        if (cnt_q == '0) begin
          start_o <= 1'b1;
          cr_q    <= byte_i[1];
        end
        if (cnt_q == CNT_W'(HDR_OCT)) type_q <= dec.code;
        if (pay_ok) begin
          pay_we_o   <= 1'b1;
          pay_addr_o <= PAY_AW'(cnt_q - CNT_W'(HDR_OCT));
          pay_data_o <= byte_i;
        end
      end
    end
  end

  AST_EOM_AT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eom_o |-> $past(flag_i)); // R10
  AST_PAY_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_we_o |-> (pay_addr_o < PAY_AW'(LONG_LEN))); // R7
  AST_EOM_ABORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eom_o && abort_o)); // R9
  AST_NO_WRITE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pay_we_o); // R1
endmodule

// File: rtl/lapd_regs.sv
module lapd_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       en_o,
  input  logic       flag_i,
  input  logic       start_i,
  input  logic       eom_i,
  input  logic       fcs_err_i,
  input  logic [1:0] type_i,
  input  logic       cr_i,
  input  logic       abort_i
);
  logic       ie_q, is_q, flag_q, eom_q, fcs_q, cr_q, abort_q;
  logic [1:0] type_q;
  logic       rd_ctrl;
  logic       unused_wdata;

  assign unused_wdata = ^{wdata_i[7:3], wdata_i[0]};
  assign rd_ctrl = rd_i && !addr_i;
  assign irq_o   = is_q;
  assign rdata_o = addr_i ? {1'b0, abort_q, type_q, cr_q, fcs_q, eom_q, flag_q}
                          : {5'b0, en_o, ie_q, is_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      ie_q    <= 1'b0;
      is_q    <= 1'b0;
      flag_q  <= 1'b0;
      eom_q   <= 1'b0;
      fcs_q   <= 1'b0;
      cr_q    <= 1'b0;
      abort_q <= 1'b0;
      type_q  <= '0;
    end else begin
      if (wr_i && !addr_i) begin
        en_o <= wdata_i[2];
        ie_q <= wdata_i[1];
      end
      if (start_i) begin
        flag_q  <= 1'b0;
        eom_q   <= 1'b0;
        fcs_q   <= 1'b0;
        abort_q <= 1'b0;
      end
      if (flag_i)  flag_q  <= 1'b1;
      if (abort_i) abort_q <= 1'b1;
      if (eom_i) begin
        eom_q  <= 1'b1;
        fcs_q  <= fcs_err_i;
        type_q <= type_i;
        cr_q   <= cr_i;
      end
      if (eom_i && ie_q) is_q <= 1'b1;
      else if (rd_ctrl)  is_q <= 1'b0;
    end
  end

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ie_q)); // R10
  AST_IRQ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ctrl && !(eom_i && ie_q)) |=> !irq_o); // R10
  AST_EOM_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eom_q) |-> $past(eom_i)); // R10
endmodule

// File: rtl/lapd_rx.sv
module lapd_rx #(
  parameter int SHORT_LEN = 76,
  parameter int LONG_LEN  = 82,
  parameter int PAY_AW    = $clog2(LONG_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dl_bit_i,
  input  logic              dl_vld_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic              reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o,
  output logic              pay_we_o,
  output logic [PAY_AW-1:0] pay_addr_o,
  output logic [7:0]        pay_data_o
);
  logic       en;
  logic       byte_vld, flag, aligned, abort_raw;
  logic [7:0] oct;
  logic       start, eom, fcs_err, cr, abort;
  logic [1:0] mtype;

  lapd_bit_deframer u_deframer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .bit_i      (dl_bit_i),
    .bit_vld_i  (dl_vld_i),
    .byte_vld_o (byte_vld),
    .byte_o     (oct),
    .flag_o     (flag),
    .aligned_o  (aligned),
    .abort_o    (abort_raw)
  );

  lapd_frame_check #(
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN),
    .PAY_AW    (PAY_AW)
  ) u_check (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .byte_vld_i (byte_vld),
    .byte_i     (oct),
    .flag_i     (flag),
    .aligned_i  (aligned),
    .abort_i    (abort_raw),
    .start_o    (start),
    .eom_o      (eom),
    .fcs_err_o  (fcs_err),
    .type_o     (mtype),
    .cr_o       (cr),
    .abort_o    (abort),
    .pay_we_o   (pay_we_o),
    .pay_addr_o (pay_addr_o),
    .pay_data_o (pay_data_o)
  );

  lapd_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .irq_o     (irq_o),
    .en_o      (en),
    .flag_i    (flag),
    .start_i   (start),
    .eom_i     (eom),
    .fcs_err_i (fcs_err),
    .type_i    (mtype),
    .cr_i      (cr),
    .abort_i   (abort)
  );
endmodule

// File: tb/lapd_rx_tb.sv
module lapd_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dl_bit = 1'b0, dl_vld = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, pay_we;
  logic [6:0] pay_addr;
  logic [7:0] pay_data;

  always #4 clk = ~clk;

  lapd_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dl_bit_i(dl_bit), .dl_vld_i(dl_vld),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .pay_we_o(pay_we), .pay_addr_o(pay_addr), .pay_data_o(pay_data)
  );

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int tx_ones = 0;
  int frm_len = 0;
  logic [7:0] mem [0:127];
  logic [7:0] frm [0:127];

  always @(posedge clk) if (pay_we) begin
    mem[pay_addr] <= pay_data;
    wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); dl_bit = b; dl_vld = 1'b1;
    @(negedge clk); dl_vld = 1'b0;
  endtask

  task automatic send_raw(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    tx_ones = 0;
  endtask

  task automatic send_stuffed(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      send_bit(v[i]);
      if (v[i]) begin
        tx_ones++;
        if (tx_ones == 5) begin send_bit(1'b0); tx_ones = 0; end
      end else tx_ones = 0;
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_addr = 1'b0; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  function automatic logic [15:0] fcs_of(input int n);
    logic [15:0] c;
    logic fb;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        fb = c[0] ^ frm[i][j];
        c = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  function automatic logic [1:0] tcode(input logic [7:0] t);
    case (t)
      8'h34: return 2'd1;
      8'h32: return 2'd2;
      8'h3F: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] exp_st(input logic [7:0] t, input logic cr, input logic fe);
    return 8'h03 | {2'b00, tcode(t), 4'h0} | {4'h0, cr, 3'b000} | {5'h0, fe, 2'b00};
  endfunction

  // fill < 0: random payload
  task automatic build(input logic [7:0] a, input logic [7:0] tei, input logic [7:0] ctl,
                       input logic [7:0] t, input int info_len, input int fill);
    logic [15:0] f;
    frm[0] = a; frm[1] = tei; frm[2] = ctl; frm[3] = t;
    for (int k = 1; k < info_len; k++)
      frm[3 + k] = (fill < 0) ? 8'($urandom) : 8'(fill);
    frm_len = 3 + info_len;
    f = fcs_of(frm_len);
    frm[frm_len] = f[7:0];
    frm[frm_len + 1] = f[15:8];
    frm_len += 2;
  endtask

  task automatic send_frame(input bit open_flag);
    if (open_flag) send_raw(8'h7E);
    for (int i = 0; i < frm_len; i++) send_stuffed(frm[i]);
    send_raw(8'h7E);
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_payload(input string tag, input int len);
    int bad;
    bad = 0;
    for (int k = 0; k < len; k++) if (mem[k] !== frm[3 + k]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] s, s_prev;
    int w0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(1'b0, s); chk("reset ctrl", s, 8'h00);
    rd(1'b1, s); chk("reset status", s, 8'h00);
    chk("reset irq", irq, 0);

    // R1: disabled receiver ignores traffic
    build(8'h3C, 8'h01, 8'h03, 8'h38, 76, -1);
    send_frame(1);
    rd(1'b1, s); chk("R1 status while disabled", s, 8'h00);
    chk("R1 no payload writes", wr_cnt, 0);

    // R2: flag present
    wr(8'h06);
    send_raw(8'h7E); repeat (6) @(negedge clk);
    rd(1'b1, s); chk("R2 flag present", s, 8'h01);

    // R10/R7/R11: good short message after idle flag
    build(8'h3C, 8'h01, 8'h03, 8'h38, 76, -1);
    w0 = wr_cnt; send_frame(1);
    rd(1'b1, s); chk("R10 status good frame", s, exp_st(8'h38, 0, 0));
    chk("R7 write count 76", wr_cnt - w0, 76);
    chk_payload("R7 payload contents", 76);
    chk("R10 irq raised", irq, 1);
    rd(1'b0, s); chk("R10 ctrl int status", s, 8'h07);
    chk("R10 irq cleared by read", irq, 0);
    rd(1'b0, s); chk("R10 ctrl after clear", s, 8'h06);

    // R3/R4/R5/R6: long message, C/R set, all-ones payload forces stuffing
    build(8'h3E, 8'h01, 8'h03, 8'h3F, 82, 8'hFF);
    w0 = wr_cnt; send_frame(1);
    rd(1'b1, s); chk("R3 status long stuffed frame", s, exp_st(8'h3F, 1, 0));
    chk("R6 write count 82", wr_cnt - w0, 82);
    chk_payload("R3 destuffed payload", 82);
    rd(1'b0, s); chk("R10 ctrl int status 2", s, 8'h07);

    // R8: corrupted check sequence
    build(8'h3C, 8'h01, 8'h03, 8'h34, 76, -1);
    frm[frm_len - 2] ^= 8'h10;
    send_frame(1);
    rd(1'b1, s); chk("R8 fcs error flagged", s, exp_st(8'h34, 0, 1));
    rd(1'b0, s); chk("R8 eom irq on bad fcs", s, 8'h07);

    // R4: header mismatches, R12 clearing of previous results
    build(8'h3C, 8'h02, 8'h03, 8'h38, 76, -1);
    w0 = wr_cnt; send_frame(1);
    rd(1'b1, s); chk("R12 R4 bad terminal octet", s & 8'h47, 8'h01);
    chk("R4 no writes on bad header", wr_cnt - w0, 0);
    chk("R4 no irq on bad header", irq, 0);
    build(8'h3D, 8'h01, 8'h03, 8'h38, 76, -1);
    send_frame(1);
    rd(1'b1, s); chk("R4 bad address octet", s & 8'h47, 8'h01);
    build(8'h3C, 8'h01, 8'h13, 8'h38, 76, -1);
    send_frame(1);
    rd(1'b1, s); chk("R4 bad control octet", s & 8'h47, 8'h01);

    // R5: unknown type
    build(8'h3C, 8'h01, 8'h03, 8'h33, 76, -1);
    w0 = wr_cnt; send_frame(1);
    rd(1'b1, s); chk("R5 unknown type dropped", s & 8'h47, 8'h01);
    chk("R5 no writes for unknown type", wr_cnt - w0, 0);

    // R6: wrong lengths
    build(8'h3C, 8'h01, 8'h03, 8'h38, 77, -1);
    w0 = wr_cnt; send_frame(1);
    rd(1'b1, s); chk("R6 long by one dropped", s & 8'h47, 8'h01);
    chk("R6 writes capped at 76", wr_cnt - w0, 76);
    build(8'h3C, 8'h01, 8'h03, 8'h3F, 76, -1);
    send_frame(1);
    rd(1'b1, s); chk("R6 short type 3F dropped", s & 8'h47, 8'h01);
    chk("R6 no irq", irq, 0);

    // R9: abort partway through a message
    send_raw(8'h7E);
    for (int i = 0; i < 10; i++) send_stuffed(8'($urandom));
    send_raw(8'hFF);
    send_raw(8'h7E); send_raw(8'h7E);
    repeat (6) @(negedge clk);
    rd(1'b1, s); chk("R9 abort flagged", s & 8'h43, 8'h41);
    chk("R9 no irq on abort", irq, 0);

    // R12: next good message clears abort
    build(8'h3C, 8'h01, 8'h03, 8'h32, 76, -1);
    send_frame(1);
    rd(1'b1, s); chk("R12 abort cleared", s, exp_st(8'h32, 0, 0));
    rd(1'b0, s);

    // R11: shared flag, then idle flags
    build(8'h3E, 8'h01, 8'h03, 8'h34, 76, -1);
    send_frame(1);
    rd(1'b1, s); chk("R11 first of pair", s, exp_st(8'h34, 1, 0));
    build(8'h3C, 8'h01, 8'h03, 8'h3F, 82, -1);
    w0 = wr_cnt; send_frame(0);
    rd(1'b1, s); chk("R11 second on shared flag", s, exp_st(8'h3F, 0, 0));
    chk("R11 second frame writes", wr_cnt - w0, 82);
    for (int i = 0; i < 3; i++) send_raw(8'h7E);
    repeat (6) @(negedge clk);
    rd(1'b1, s); chk("R11 idle flags keep status", s, exp_st(8'h3F, 0, 0));
    rd(1'b0, s);

    // R10: interrupt disabled
    wr(8'h04);
    build(8'h3C, 8'h01, 8'h03, 8'h38, 76, -1);
    send_frame(1);
    chk("R10 no irq when disabled", irq, 0);
    rd(1'b0, s); chk("R10 ctrl without ie", s, 8'h04);
    rd(1'b1, s_prev); chk("R10 eom without ie", s_prev, exp_st(8'h38, 0, 0));

    // R1: receiver disabled after use, status frozen
    wr(8'h00);
    build(8'h3E, 8'h01, 8'h03, 8'h3F, 82, -1);
    w0 = wr_cnt; send_frame(1);
    rd(1'b1, s); chk("R1 status frozen", s, s_prev);
    chk("R1 no writes when off", wr_cnt - w0, 0);

    // random mix
    wr(8'h06);
    for (int n = 0; n < 8; n++) begin
      logic [7:0] t, a;
      logic cr, bad;
      int len;
      case ($urandom % 4)
        0: t = 8'h38;
        1: t = 8'h34;
        2: t = 8'h32;
        default: t = 8'h3F;
      endcase
      cr  = 1'($urandom % 2);
      bad = ($urandom % 3) == 0;
      a   = cr ? 8'h3E : 8'h3C;
      len = (t == 8'h3F) ? 82 : 76;
      build(a, 8'h01, 8'h03, t, len, -1);
      if (bad) frm[frm_len - 1] ^= 8'h01;
      w0 = wr_cnt; send_frame(1);
      rd(1'b1, s); chk("R8 random frame status", s, exp_st(t, cr, bad));
      chk("R7 random frame writes", wr_cnt - w0, len);
      chk_payload("R7 random payload", len);
      rd(1'b0, s); chk("R10 random irq status", s, 8'h07);
    end

    finish_run();
  end
endmodule